// File: doc/BRIEF.md
# Bank Key Protection Guard

This block keeps programs that run in user memory away from supervisor memory. The address space is divided into banks, and each bank holds an access key. A key of zero marks the bank as supervisor memory. Any other value marks it as user memory. A global protection switch turns the rule on or off. The bank the program counter is currently executing in is an input. When a subroutine call moves execution into a bank with a nonzero key, the guard is in user mode. It stays there until a return or an interrupt entry moves execution back to a bank whose key is zero.

Every bus cycle names a target bank. While protection is on and the current bank is keyed, the access goes through only if the target bank carries the same key as the current bank. A refused access does three things:
- it holds the memory chip-enable low;
- it returns 0xFF as read data;
- it raises a sticky fault flag, which only supervisor code can clear.

Keys and the protection switch are written through a small register-write port. Writes made from user mode are dropped. The mode output is combinational from the current bank's key, so it follows a bank change in the same cycle.

Top module: `bkp_guard`

## Requirements
- R1: After reset every bank key is 0, protection is off, the sticky fault is 0, and user_mode_o is 0.
- R2: While protection is off, every requested access is granted: mem_ce_o=1, deny_o=0, and bus_rdata_o equals mem_rdata_i, whatever the keys hold. In this state user_mode_o is 0.
- R3: While protection is on and the current bank's key is 0 (supervisor), accesses to every bank are granted.
- R4: In user mode, an access to a bank whose key equals the current bank's key is granted. This includes the current bank itself.
- R5: In user mode, an access to a bank whose key differs from the current key is refused in the same cycle: deny_o=1, mem_ce_o=0, bus_rdata_o=8'hFF. This includes every bank with key 0.
- R6: A refused access sets fault_sticky_o from the next clock edge. The flag stays set until it is cleared.
- R7: A fault clear request (flt_clr_i=1) takes effect at the next edge only when made in supervisor mode. In user mode it is ignored.
- R8: A key write made in supervisor mode takes effect from the next clock edge. A key write made in user mode is ignored.
- R9: A write to the protection switch (cfg_prot_i: 1=on, 0=off) is ignored in user mode.
- R10: user_mode_o is 1 exactly when protection is on and the key of the bank on exec_bank_i is nonzero. It changes in the same cycle as exec_bank_i.
- R11: Without a bus request, mem_ce_o=0 and deny_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_key_we_i | input | 1 | Key write strobe |
| cfg_bank_i | input | BANK_W | Bank whose key is written |
| cfg_key_i | input | KEY_W | Key value to write |
| cfg_prot_we_i | input | 1 | Protection switch write strobe |
| cfg_prot_i | input | 1 | Protection switch value (1=on) |
| flt_clr_i | input | 1 | Sticky fault clear request |
| exec_bank_i | input | BANK_W | Bank the program counter runs in |
| bus_req_i | input | 1 | Bus cycle valid |
| bus_bank_i | input | BANK_W | Target bank of the bus cycle |
| mem_rdata_i | input | DATA_W | Read data from memory |
| mem_ce_o | output | 1 | Memory chip-enable |
| bus_rdata_o | output | DATA_W | Read data returned to the core |
| deny_o | output | 1 | Current access refused |
| fault_sticky_o | output | 1 | Sticky fault flag |
| user_mode_o | output | 1 | 1 while running in user mode |

## Verification
The access check is tried from four points of view:
- with protection off while keys are loaded, which shows that the switch alone gates the rule;
- from a supervisor bank into keyed and unkeyed banks;
- from a keyed bank into a bank sharing its key, which must pass;
- from a keyed bank into key-0 banks and into a bank with another nonzero key, which separates a plain "target is keyed" test from true key equality.

Clear, key and switch writes are each issued once from user mode and once from supervisor mode. The ignored cases are observed through later accesses and through the mode output.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  localparam int unsigned BKP_NUM_BANKS = 16;
  localparam int unsigned BKP_KEY_W     = 8;
  localparam int unsigned BKP_DATA_W    = 8;

  typedef enum logic {
    MODE_SUPER = 1'b0,
    MODE_USER  = 1'b1
  } bkp_mode_e;
endpackage

// File: rtl/bkp_rst_sync.sv
module bkp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/bkp_key_file.sv
module bkp_key_file #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned KEY_W     = 8,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_allow,
  input  logic [BANK_W-1:0]               wr_bank,
  input  logic [KEY_W-1:0]                wr_key,
  output logic [NUM_BANKS-1:0][KEY_W-1:0] keys_o
);
  logic wr_ok;
  assign wr_ok = wr_en & wr_allow;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             load;
    logic [KEY_W-1:0] key_d;
    logic [KEY_W-1:0] key_q;

    always_comb begin
      load  = wr_ok && (wr_bank == BANK_W'(b));
      key_d = wr_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    key_q <= '0;
      else if (load) key_q <= key_d;
    end

    assign keys_o[b] = key_q;
  end
endmodule

// File: rtl/bkp_access_check.sv
module bkp_access_check #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned KEY_W     = 8,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0][KEY_W-1:0] keys_i,
  input  logic                            prot_on_i,
  input  logic [BANK_W-1:0]               exec_bank_i,
  input  logic                            req_i,
  input  logic [BANK_W-1:0]               tgt_bank_i,
  output bkp_pkg::bkp_mode_e              mode_o,
  output logic                            grant_o,
  output logic                            deny_o
);
  logic [KEY_W-1:0] cur_key;
  logic [KEY_W-1:0] tgt_key;
  logic             keys_match;

  always_comb begin
    cur_key    = keys_i[exec_bank_i];
    tgt_key    = keys_i[tgt_bank_i];
    keys_match = (cur_key == tgt_key);
    if (prot_on_i && (cur_key != '0)) mode_o = bkp_pkg::MODE_USER;
    else                              mode_o = bkp_pkg::MODE_SUPER;
    grant_o = req_i && ((mode_o == bkp_pkg::MODE_SUPER) || keys_match);
    deny_o  = req_i && !grant_o;
  end
endmodule

// File: rtl/bkp_fault_reg.sv
module bkp_fault_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic clr_allow_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | (clr_i & clr_allow_i);
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/bkp_guard.sv
module bkp_guard #(
  parameter int unsigned NUM_BANKS = bkp_pkg::BKP_NUM_BANKS,
  parameter int unsigned KEY_W     = bkp_pkg::BKP_KEY_W,
  parameter int unsigned DATA_W    = bkp_pkg::BKP_DATA_W,
  parameter int unsigned BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_key_we_i,
  input  logic [BANK_W-1:0] cfg_bank_i,
  input  logic [KEY_W-1:0]  cfg_key_i,
  input  logic              cfg_prot_we_i,
  input  logic              cfg_prot_i,
  input  logic              flt_clr_i,
  input  logic [BANK_W-1:0] exec_bank_i,
  input  logic              bus_req_i,
  input  logic [BANK_W-1:0] bus_bank_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_ce_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              deny_o,
  output logic              fault_sticky_o,
  output logic              user_mode_o
);
  localparam logic [DATA_W-1:0] BLOCKED_DATA = '1;

  logic                            rst_sync_n;
  logic [NUM_BANKS-1:0][KEY_W-1:0] key_tbl;
  logic                            prot_q;
  logic                            prot_d;
  logic                            prot_en;
  logic                            is_super;
  logic                            grant;
  logic                            deny;
  bkp_pkg::bkp_mode_e              mode;

  bkp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bkp_key_file #(
    .NUM_BANKS (NUM_BANKS),
    .KEY_W     (KEY_W),
    .BANK_W    (BANK_W)
  ) u_keys (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_key_we_i),
    .wr_allow (is_super),
    .wr_bank  (cfg_bank_i),
    .wr_key   (cfg_key_i),
    .keys_o   (key_tbl)
  );

  bkp_access_check #(
    .NUM_BANKS (NUM_BANKS),
    .KEY_W     (KEY_W),
    .BANK_W    (BANK_W)
  ) u_check (
    .keys_i      (key_tbl),
    .prot_on_i   (prot_q),
    .exec_bank_i (exec_bank_i),
    .req_i       (bus_req_i),
    .tgt_bank_i  (bus_bank_i),
    .mode_o      (mode),
    .grant_o     (grant),
    .deny_o      (deny)
  );

  bkp_fault_reg u_fault (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .set_i       (deny),
    .clr_i       (flt_clr_i),
    .clr_allow_i (is_super),
    .flag_o      (fault_sticky_o)
  );

  // Protection switch: next-state and register split
  always_comb begin
    is_super = (mode == bkp_pkg::MODE_SUPER);
    prot_en  = cfg_prot_we_i & is_super;
    prot_d   = cfg_prot_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  prot_q <= 1'b0;
    else if (prot_en) prot_q <= prot_d;
  end

  assign mem_ce_o    = grant;
  assign deny_o      = deny;
  assign bus_rdata_o = deny ? BLOCKED_DATA : mem_rdata_i;
  assign user_mode_o = (mode == bkp_pkg::MODE_USER);
endmodule

// File: rtl/bkp_guard_chk.sv
module bkp_guard_chk #(
  parameter int unsigned NUM_BANKS = 16,
  parameter int unsigned KEY_W     = 8,
  parameter int unsigned DATA_W    = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            bus_req_i,
  input logic                            cfg_key_we_i,
  input logic                            cfg_prot_we_i,
  input logic                            flt_clr_i,
  input logic                            mem_ce_o,
  input logic [DATA_W-1:0]               bus_rdata_o,
  input logic                            deny_o,
  input logic                            fault_sticky_o,
  input logic                            user_mode_o,
  input logic                            prot_q,
  input logic [NUM_BANKS-1:0][KEY_W-1:0] key_tbl
);
  assert_ce_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_o || deny_o) |-> bus_req_i);

  assert_deny_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |-> (!mem_ce_o && bus_rdata_o == '1));

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |=> fault_sticky_o);

  assert_user_clear_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sticky_o && user_mode_o) |=> fault_sticky_o);

  assert_user_keywr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && cfg_key_we_i) |=> $stable(key_tbl));

  assert_user_protwr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && cfg_prot_we_i) |=> $stable(prot_q));

  assert_user_needs_prot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode_o |-> prot_q);

  assert_super_no_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode_o |-> !deny_o);
endmodule

bind bkp_guard bkp_guard_chk #(
  .NUM_BANKS (NUM_BANKS),
  .KEY_W     (KEY_W),
  .DATA_W    (DATA_W)
) u_bkp_guard_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .bus_req_i      (bus_req_i),
  .cfg_key_we_i   (cfg_key_we_i),
  .cfg_prot_we_i  (cfg_prot_we_i),
  .flt_clr_i      (flt_clr_i),
  .mem_ce_o       (mem_ce_o),
  .bus_rdata_o    (bus_rdata_o),
  .deny_o         (deny_o),
  .fault_sticky_o (fault_sticky_o),
  .user_mode_o    (user_mode_o),
  .prot_q         (prot_q),
  .key_tbl        (key_tbl)
);

// File: tb/test_bkp_guard.sv
`timescale 1ns/1ps
module test_bkp_guard;
  localparam int BW = 4;

  logic          clk;
  logic          rst_n;
  logic          cfg_key_we_i;
  logic [BW-1:0] cfg_bank_i;
  logic [7:0]    cfg_key_i;
  logic          cfg_prot_we_i;
  logic          cfg_prot_i;
  logic          flt_clr_i;
  logic [BW-1:0] exec_bank_i;
  logic          bus_req_i;
  logic [BW-1:0] bus_bank_i;
  logic [7:0]    mem_rdata_i;
  logic          mem_ce_o;
  logic [7:0]    bus_rdata_o;
  logic          deny_o;
  logic          fault_sticky_o;
  logic          user_mode_o;

  int n_chk  = 0;
  int n_fail = 0;

  bkp_guard i_bkp_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_key_we_i   (cfg_key_we_i),
    .cfg_bank_i     (cfg_bank_i),
    .cfg_key_i      (cfg_key_i),
    .cfg_prot_we_i  (cfg_prot_we_i),
    .cfg_prot_i     (cfg_prot_i),
    .flt_clr_i      (flt_clr_i),
    .exec_bank_i    (exec_bank_i),
    .bus_req_i      (bus_req_i),
    .bus_bank_i     (bus_bank_i),
    .mem_rdata_i    (mem_rdata_i),
    .mem_ce_o       (mem_ce_o),
    .bus_rdata_o    (bus_rdata_o),
    .deny_o         (deny_o),
    .fault_sticky_o (fault_sticky_o),
    .user_mode_o    (user_mode_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // advance one edge, land on the following falling edge
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_key(input logic [BW-1:0] b, input logic [7:0] k);
    cfg_key_we_i = 1'b1; cfg_bank_i = b; cfg_key_i = k;
    cyc();
    cfg_key_we_i = 1'b0;
  endtask

  task automatic set_prot(input logic v);
    cfg_prot_we_i = 1'b1; cfg_prot_i = v;
    cyc();
    cfg_prot_we_i = 1'b0;
  endtask

  task automatic probe(input logic [BW-1:0] b);
    bus_req_i = 1'b1; bus_bank_i = b;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 user_mode", user_mode_o, 0);
    chk("R1 sticky", fault_sticky_o, 0);
    chk("R1 ce idle", mem_ce_o, 0);
    set_prot(1'b1);
    exec_bank_i = 4'd5; #1;
    chk("R1 key zero after reset", user_mode_o, 0);
    exec_bank_i = 4'd0;
    set_prot(1'b0);
  endtask

  task automatic t_prot_off();
    exec_bank_i = 4'd0;
    set_key(4'd1, 8'h12);
    exec_bank_i = 4'd1; #1;
    chk("R2 no user mode while off", user_mode_o, 0);
    probe(4'd0);
    chk("R2 ce", mem_ce_o, 1);
    chk("R2 deny", deny_o, 0);
    chk("R2 rdata", bus_rdata_o, 32'h5A);
    bus_req_i = 1'b0;
  endtask

  task automatic t_supervisor();
    exec_bank_i = 4'd0;
    set_prot(1'b1);
    probe(4'd1);
    chk("R3 ce keyed bank", mem_ce_o, 1);
    chk("R3 deny keyed bank", deny_o, 0);
    probe(4'd7);
    chk("R3 ce plain bank", mem_ce_o, 1);
    bus_req_i = 1'b0;
  endtask

  task automatic t_mode();
    exec_bank_i = 4'd1; #1;
    chk("R10 user on bank change", user_mode_o, 1);
    exec_bank_i = 4'd0; #1;
    chk("R10 super on bank change", user_mode_o, 0);
  endtask

  task automatic t_user_same();
    exec_bank_i = 4'd0;
    set_key(4'd3, 8'h12);
    exec_bank_i = 4'd1;
    probe(4'd3);
    chk("R4 ce shared key", mem_ce_o, 1);
    chk("R4 rdata shared key", bus_rdata_o, 32'h5A);
    probe(4'd1);
    chk("R4 ce own bank", mem_ce_o, 1);
    bus_req_i = 1'b0;
  endtask

  task automatic t_user_deny();
    exec_bank_i = 4'd0;
    set_key(4'd4, 8'h34);
    exec_bank_i = 4'd1; #1;
    chk("R6 sticky clear before", fault_sticky_o, 0);
    probe(4'd0);
    chk("R5 deny super bank", deny_o, 1);
    chk("R5 ce blocked", mem_ce_o, 0);
    chk("R5 rdata FF", bus_rdata_o, 32'hFF);
    cyc();
    bus_req_i = 1'b0; #1;
    chk("R6 sticky set", fault_sticky_o, 1);
    probe(4'd4);
    chk("R5 deny other key", deny_o, 1);
    probe(4'd2);
    chk("R5 deny key0 bank", deny_o, 1);
    bus_req_i = 1'b0;
    cyc(); cyc();
    chk("R6 sticky holds", fault_sticky_o, 1);
  endtask

  task automatic t_clear();
    exec_bank_i = 4'd1; flt_clr_i = 1'b1;
    cyc();
    flt_clr_i = 1'b0; #1;
    chk("R7 user clear ignored", fault_sticky_o, 1);
    exec_bank_i = 4'd0; flt_clr_i = 1'b1;
    cyc();
    flt_clr_i = 1'b0; #1;
    chk("R7 super clear", fault_sticky_o, 0);
  endtask

  task automatic t_key_guard();
    exec_bank_i = 4'd1;
    set_key(4'd2, 8'h12);
    probe(4'd2);
    chk("R8 user key write ignored", deny_o, 1);
    bus_req_i = 1'b0;
    exec_bank_i = 4'd0;
    set_key(4'd2, 8'h12);
    exec_bank_i = 4'd1;
    probe(4'd2);
    chk("R8 super key write effective", deny_o, 0);
    bus_req_i = 1'b0;
    exec_bank_i = 4'd0; flt_clr_i = 1'b1;
    cyc();
    flt_clr_i = 1'b0;
  endtask

  task automatic t_prot_guard();
    exec_bank_i = 4'd1;
    set_prot(1'b0); #1;
    chk("R9 user switch write ignored", user_mode_o, 1);
    exec_bank_i = 4'd0;
    set_prot(1'b0);
    exec_bank_i = 4'd1; #1;
    chk("R9 super switch write", user_mode_o, 0);
    probe(4'd0);
    chk("R2 open after switch off", mem_ce_o, 1);
    bus_req_i = 1'b0;
  endtask

  task automatic t_no_req();
    exec_bank_i = 4'd0;
    set_prot(1'b1);
    exec_bank_i = 4'd1; bus_req_i = 1'b0; bus_bank_i = 4'd0; #1;
    chk("R11 ce idle", mem_ce_o, 0);
    chk("R11 deny idle", deny_o, 0);
    cyc();
    chk("R11 no sticky without request", fault_sticky_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_key_we_i = 1'b0; cfg_bank_i = '0; cfg_key_i = '0;
    cfg_prot_we_i = 1'b0; cfg_prot_i = 1'b0; flt_clr_i = 1'b0;
    exec_bank_i = '0; bus_req_i = 1'b0; bus_bank_i = '0; mem_rdata_i = 8'h5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_prot_off();
    t_supervisor();
    t_mode();
    t_user_same();
    t_user_deny();
    t_clear();
    t_key_guard();
    t_prot_guard();
    t_no_req();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule